// File: doc/BRIEF.md
# Four-Channel Prioritised Transfer Engine with Audio Refill Mode

This block moves data on behalf of a processor through four independent transfer channels. Each channel holds a programmed source address, destination address, unit count and control word. Once a channel is armed and its start condition occurs, it becomes in progress. It then moves one unit per step over a single bus-master port. Each step is a read cycle at the current source address followed by a write cycle at the current destination address. After each step the channel moves its addresses and counts down. When its count runs out it may raise a one-cycle interrupt pulse.

Channels start at once when enabled, on a vertical or horizontal blanking pulse, or, on channels 1 and 2 only, on a request from an audio sample queue. In that audio mode a four-word burst of 32-bit units is written to a fixed destination. The engine is a three-state machine. ST_IDLE moves to ST_READ when any channel is in progress and stays in ST_IDLE otherwise. ST_READ always moves to ST_WRITE. ST_WRITE always moves back to ST_IDLE. The channel is chosen again in every ST_IDLE cycle, so a higher-priority channel can take over between steps.

Top module: `dmac_top`

## Requirements
- R1: After reset the read strobe, the write strobe and all interrupt outputs are low, and no channel is in progress.
- R2: Each step is one read cycle at the source followed by one write cycle at the destination, which carries the data read. Steps are followed by one idle cycle. The step goes to the lowest-numbered in-progress channel, so channel 0 beats 1, 1 beats 2 and 2 beats 3.
- R3: The register select values are 0 source, 1 destination, 2 count and 3 control. Control bits are [0] enable, [2:1] start mode, [3] repeat, [4] interrupt enable, [5] 32-bit width, [7:6] destination adjust and [9:8] source adjust. The start mode is 0 immediate, 1 vertical blank, 2 horizontal blank and 3 audio. A 0-to-1 change of enable loads the working source, destination and count. Only start mode 0 begins transferring at that moment.
- R4: A programmed count of 0 loads the working counter with its all-ones value, 2^CNT_W-1 units.
- R5: Source addresses are masked to 27 bits on channel 0 and to 28 bits on channels 1-3. Destination addresses are masked to 28 bits on channel 3 and to 27 bits on channels 0-2.
- R6: The adjust code is 0 increment, 1 decrement, 2 fixed and 3 increment-with-reload. The address step is 4 bytes with the width bit set and 2 bytes without it.
- R7: When the count runs out, the channel pulses its interrupt output for one cycle if interrupt enable is set. It clears its enable bit unless repeat is set, and it leaves the in-progress state.
- R8: A blanking pulse of the matching kind restarts an enabled channel that is not in progress. It reloads the count, and reloads the destination only when the destination adjust code is 3. The source carries on from where it stopped.
- R9: An audio request to an enabled channel 1 or 2 in start mode 3 forces repeat on and starts a burst of 4 units. The units are 32 bits wide and the destination is held fixed.
- R10: An audio request has no effect while the channel is in progress, or when its start mode is not 3.
- R11: A blanking pulse has no effect on a channel whose start mode does not match it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel addressed by the write |
| reg_sel | input | 2 | Register addressed: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Register write data |
| hblank | input | 1 | Horizontal blanking pulse |
| vblank | input | 1 | Vertical blanking pulse |
| snd_req | input | 2 | Audio refill requests; bit 0 for channel 1, bit 1 for channel 2 |
| bus_rdata | input | 32 | Read data, valid in the read cycle |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_wide | output | 1 | 1 for a 32-bit unit, 0 for a 16-bit unit |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| irq | output | 4 | Per-channel completion pulses |

## Verification
A corrupted working address shows up on bus_addr in the very next read or write cycle, within three cycles of the fault. A wrong working count does not show until the end of the burst: it appears as an extra or missing write and as an early or late interrupt pulse. A lost enable or repeat bit shows only at the next blanking pulse or audio request, as a missing burst or a surplus one. For that reason every scenario fires its start condition a second time.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int N_CH   = 4;
    localparam int CTRL_W = 10;
    localparam int FIFO_BURST = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} eng_state_t;
    typedef enum logic [1:0] {TM_NOW = 2'd0, TM_VBL = 2'd1, TM_HBL = 2'd2, TM_AUDIO = 2'd3} timing_t;
    typedef enum logic [1:0] {ADJ_INC = 2'd0, ADJ_DEC = 2'd1, ADJ_FIX = 2'd2, ADJ_RELOAD = 2'd3} adj_t;

    typedef struct packed {
        adj_t    src_adj;
        adj_t    dst_adj;
        logic    wide;
        logic    irq_en;
        logic    rpt;
        timing_t timing;
        logic    enable;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] MASK27 = ADDR_W'((64'd1 << 27) - 64'd1);
    localparam logic [ADDR_W-1:0] MASK28 = ADDR_W'((64'd1 << 28) - 64'd1);

    function automatic logic [ADDR_W-1:0] src_mask(input int idx);
        return (idx == 0) ? MASK27 : MASK28;
    endfunction

    function automatic logic [ADDR_W-1:0] dst_mask(input int idx);
        return (idx == N_CH - 1) ? MASK28 : MASK27;
    endfunction
endpackage

// File: rtl/dmac_arbiter.sv
module dmac_arbiter
    import dmac_pkg::*;
#(
    parameter int NCH = N_CH,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]   req,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);
    always_comb begin
        grant_idx = '0;
        any       = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant_idx = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int CNT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              snd_req,
    input  logic              step_done,
    output logic              busy,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              wide,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] SRC_MASK = src_mask(IDX);
    localparam logic [ADDR_W-1:0] DST_MASK = dst_mask(IDX);
    localparam logic              FIFO_OK  = (IDX == 1) || (IDX == 2);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;

    logic [ADDR_W-1:0] sad_q, dad_q, cur_src, cur_dst, unit;
    logic [CNT_W-1:0]  wcnt_q, cur_cnt, load_cnt;
    ctrl_t             ctrl_q, ctrl_new;
    logic              fifo_mode, blank_hit, snd_hit, last_unit;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                    input adj_t adj,
                                                    input logic [ADDR_W-1:0] u);
        unique case (adj)
            ADJ_INC, ADJ_RELOAD: return a + u;
            ADJ_DEC:             return a - u;
            default:             return a;
        endcase
    endfunction

    assign ctrl_new  = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    assign fifo_mode = FIFO_OK && (ctrl_q.timing == TM_AUDIO);
    assign unit      = (fifo_mode || ctrl_q.wide) ? ADDR_W'(4) : ADDR_W'(2);
    assign load_cnt  = (wcnt_q == '0) ? CNT_MAX : wcnt_q;
    assign last_unit = (cur_cnt == CNT_W'(1));
    assign blank_hit = !busy && ctrl_q.enable &&
                       ((vblank && ctrl_q.timing == TM_VBL) || (hblank && ctrl_q.timing == TM_HBL));
    assign snd_hit   = snd_req && fifo_mode && !busy && ctrl_q.enable;

    assign src_addr = cur_src;
    assign dst_addr = cur_dst;
    assign wide     = fifo_mode || ctrl_q.wide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sad_q   <= '0;
            dad_q   <= '0;
            wcnt_q  <= '0;
            ctrl_q  <= '0;
            cur_src <= '0;
            cur_dst <= '0;
            cur_cnt <= '0;
            busy    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (reg_wr) begin
                unique case (reg_sel)
                    2'd0: sad_q  <= reg_wdata & SRC_MASK;
                    2'd1: dad_q  <= reg_wdata & DST_MASK;
                    2'd2: wcnt_q <= reg_wdata[CNT_W-1:0];
                    default: begin
                        ctrl_q <= ctrl_new;
                        if (ctrl_new.enable && !ctrl_q.enable) begin
                            cur_src <= sad_q;
                            cur_dst <= dad_q;
                            cur_cnt <= load_cnt;
                            busy    <= (ctrl_new.timing == TM_NOW);
                        end else if (!ctrl_new.enable) begin
                            busy <= 1'b0;
                        end
                    end
                endcase
            end else if (step_done && busy) begin
                cur_src <= step_addr(cur_src, ctrl_q.src_adj, unit) & SRC_MASK;
                if (!fifo_mode)
                    cur_dst <= step_addr(cur_dst, ctrl_q.dst_adj, unit) & DST_MASK;
                cur_cnt <= cur_cnt - CNT_W'(1);
                if (last_unit) begin
                    irq  <= ctrl_q.irq_en;
                    busy <= 1'b0;
                    if (!ctrl_q.rpt) ctrl_q.enable <= 1'b0;
                end
            end else if (blank_hit) begin
                busy    <= 1'b1;
                cur_cnt <= load_cnt;
                if (ctrl_q.dst_adj == ADJ_RELOAD) cur_dst <= dad_q;
            end else if (snd_hit) begin
                busy       <= 1'b1;
                cur_cnt    <= CNT_W'(FIFO_BURST);
                ctrl_q.rpt <= 1'b1;
            end
        end
    end

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_src_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((cur_src & ~SRC_MASK) == '0 && (cur_dst & ~DST_MASK) == '0));
    assert_fifo_dst_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && busy && fifo_mode && !reg_wr) |=> $stable(cur_dst));
    assert_count_keeps_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && busy && !reg_wr && !last_unit) |=> busy);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int NCH = N_CH,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             busy,
    input  logic [NCH-1:0][ADDR_W-1:0] src_addr,
    input  logic [NCH-1:0][ADDR_W-1:0] dst_addr,
    input  logic [NCH-1:0]             wide,
    input  logic [DATA_W-1:0]          bus_rdata,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [DATA_W-1:0]          bus_wdata,
    output logic                       bus_wide,
    output logic                       bus_rd,
    output logic                       bus_wr,
    output logic [NCH-1:0]             step_done
);
    eng_state_t        state_q, state_d;
    logic [IDX_W-1:0]  sel_q, grant_idx;
    logic              any;
    logic [DATA_W-1:0] data_q;
    logic [NCH-1:0]    below_sel;

    dmac_arbiter #(.NCH(NCH)) u_arb (
        .req       (busy),
        .grant_idx (grant_idx),
        .any       (any)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = any ? ST_READ : ST_IDLE;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && any) sel_q <= grant_idx;
            if (state_q == ST_READ) data_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_wide  = 1'b0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        step_done = '0;
        unique case (state_q)
            ST_READ: begin
                bus_rd   = 1'b1;
                bus_addr = src_addr[sel_q];
                bus_wide = wide[sel_q];
            end
            ST_WRITE: begin
                bus_wr    = 1'b1;
                bus_addr  = dst_addr[sel_q];
                bus_wdata = data_q;
                bus_wide  = wide[sel_q];
                step_done = NCH'(1) << sel_q;
            end
            default: ;
        endcase
    end

    assign below_sel = (NCH'(1) << sel_q) - NCH'(1);

    assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);
    assert_lowest_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(state_q) == ST_IDLE) |-> (($past(busy) & below_sel) == '0));
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_ch,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              hblank,
    input  logic              vblank,
    input  logic [1:0]        snd_req,
    input  logic [31:0]       bus_rdata,
    output logic [31:0]       bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              bus_wide,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [3:0]        irq
);
    logic [N_CH-1:0]             busy, wide, step_done, snd_ch;
    logic [N_CH-1:0][ADDR_W-1:0] src_addr, dst_addr;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        if (g == 1)      assign snd_ch[g] = snd_req[0];
        else if (g == 2) assign snd_ch[g] = snd_req[1];
        else             assign snd_ch[g] = 1'b0;

        dmac_channel #(.IDX(g), .CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .reg_wr    (reg_wr && (reg_ch == 2'(g))),
            .reg_sel   (reg_sel),
            .reg_wdata (reg_wdata),
            .hblank    (hblank),
            .vblank    (vblank),
            .snd_req   (snd_ch[g]),
            .step_done (step_done[g]),
            .busy      (busy[g]),
            .src_addr  (src_addr[g]),
            .dst_addr  (dst_addr[g]),
            .wide      (wide[g]),
            .irq       (irq[g])
        );
    end

    dmac_engine #(.NCH(N_CH)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .wide      (wide),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wide  (bus_wide),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .step_done (step_done)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_rd && !bus_wr && irq == '0));
endmodule

// File: tb/dmac_top_bench.sv
module dmac_top_bench;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_ch = '0, reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        hblank = 1'b0, vblank = 1'b0;
    logic [1:0]  snd_req = '0;
    logic [31:0] bus_rdata, bus_addr, bus_wdata;
    logic        bus_wide, bus_rd, bus_wr;
    logic [3:0]  irq;

    always #2 clk = ~clk;

    function automatic logic [31:0] mem(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction
    assign bus_rdata = mem(bus_addr);

    dmac_top #(.CNT_W(CW)) u_dmac_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .hblank(hblank), .vblank(vblank), .snd_req(snd_req),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wide(bus_wide), .bus_rd(bus_rd), .bus_wr(bus_wr), .irq(irq)
    );

    int checks = 0, fails = 0, nw = 0;
    int irqn [4];
    logic [31:0] wa [0:511];
    logic [31:0] wd [0:511];
    logic [31:0] ra [0:511];
    logic        ww [0:511];
    logic [31:0] last_ra = '0;
    bit          done = 1'b0;

    always @(negedge clk) begin
        if (bus_rd) last_ra <= bus_addr;
        if (bus_wr && nw < 512) begin
            wa[nw] <= bus_addr; wd[nw] <= bus_wdata; ww[nw] <= bus_wide; ra[nw] <= last_ra;
            nw <= nw + 1;
        end
        for (int i = 0; i < 4; i++) if (irq[i]) irqn[i] <= irqn[i] + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input logic [1:0] tm, input bit rpt, input bit ie,
                                       input bit wd32, input logic [1:0] dadj, input logic [1:0] sadj);
        return {22'd0, sadj, dadj, wd32, ie, rpt, tm, en};
    endfunction

    task automatic wreg(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d, input int n);
        wreg(ch, 0, s); wreg(ch, 1, d); wreg(ch, 2, 32'(n));
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 8) begin
            @(negedge clk);
            if (bus_rd || bus_wr) q = 0; else q++;
        end
    endtask

    task automatic clear_log();
        quiet();
        nw = 0;
        for (int i = 0; i < 4; i++) irqn[i] = 0;
    endtask

    task automatic pulse_blank(input bit v);
        @(negedge clk);
        if (v) vblank = 1'b1; else hblank = 1'b1;
        @(negedge clk);
        vblank = 1'b0; hblank = 1'b0;
    endtask

    task automatic pulse_snd(input int b);
        @(negedge clk);
        snd_req[b] = 1'b1;
        @(negedge clk);
        snd_req = '0;
    endtask

    task automatic t_reset();
        chk(!bus_rd && !bus_wr, "R1 strobes after reset", {30'd0, bus_rd, bus_wr}, 0);
        chk(irq == 0, "R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_immediate();
        clear_log();
        setup(3, 32'h0300_0000, 32'h0200_0000, 3);
        wreg(3, 3, cw(1, 2'd0, 0, 1, 1, 2'd0, 2'd0));
        quiet();
        chk(nw == 3, "R3 immediate unit count", nw, 3);
        for (int i = 0; i < 3; i++) begin
            chk(wa[i] == 32'h0200_0000 + 4 * i, "R6 incrementing destination", wa[i], 32'h0200_0000 + 4 * i);
            chk(ra[i] == 32'h0300_0000 + 4 * i, "R6 incrementing source", ra[i], 32'h0300_0000 + 4 * i);
            chk(wd[i] == mem(ra[i]) && ww[i], "R2 write carries read data", wd[i], mem(ra[i]));
        end
        chk(irqn[3] == 1, "R7 completion pulse", irqn[3], 1);
        clear_log();
        wreg(3, 3, cw(1, 2'd0, 0, 1, 1, 2'd0, 2'd0));
        quiet();
        chk(nw == 3, "R7 enable cleared so rewrite rearms", nw, 3);
    endtask

    task automatic t_half_dec();
        clear_log();
        setup(3, 32'h0300_0100, 32'h0200_0100, 3);
        wreg(3, 3, cw(1, 2'd0, 0, 0, 0, 2'd2, 2'd1));
        quiet();
        chk(nw == 3, "R6 halfword count", nw, 3);
        for (int i = 0; i < 3; i++) begin
            chk(ra[i] == 32'h0300_0100 - 2 * i, "R6 decrement by 2", ra[i], 32'h0300_0100 - 2 * i);
            chk(wa[i] == 32'h0200_0100 && !ww[i], "R6 fixed destination", wa[i], 32'h0200_0100);
        end
        chk(irqn[3] == 0, "R7 no pulse with interrupt disabled", irqn[3], 0);
    endtask

    task automatic t_priority();
        logic [31:0] exp [6];
        clear_log();
        setup(2, 32'h0100_0000, 32'h0210_0000, 4);
        setup(0, 32'h0110_0000, 32'h0220_0000, 2);
        wreg(2, 3, cw(1, 2'd0, 0, 0, 1, 2'd0, 2'd0));
        wreg(0, 3, cw(1, 2'd0, 0, 0, 1, 2'd0, 2'd0));
        quiet();
        exp = '{32'h0210_0000, 32'h0220_0000, 32'h0220_0004, 32'h0210_0004, 32'h0210_0008, 32'h0210_000C};
        chk(nw == 6, "R2 preemption total", nw, 6);
        for (int i = 0; i < 6; i++) chk(wa[i] == exp[i], "R2 channel 0 preempts channel 2", wa[i], exp[i]);
    endtask

    task automatic t_blank();
        clear_log();
        setup(1, 32'h0120_0000, 32'h0230_0000, 2);
        wreg(1, 3, cw(1, 2'd1, 1, 1, 1, 2'd3, 2'd0));
        quiet();
        chk(nw == 0, "R3 vblank mode waits after enable", nw, 0);
        pulse_blank(0);
        quiet();
        chk(nw == 0, "R11 hblank ignored by vblank channel", nw, 0);
        pulse_blank(1);
        quiet();
        pulse_blank(1);
        quiet();
        chk(nw == 4, "R8 two vblank bursts", nw, 4);
        for (int i = 0; i < 4; i++) begin
            chk(wa[i] == 32'h0230_0000 + 4 * (i % 2), "R8 destination reloaded", wa[i], 32'h0230_0000 + 4 * (i % 2));
            chk(ra[i] == 32'h0120_0000 + 4 * i, "R8 source continues", ra[i], 32'h0120_0000 + 4 * i);
        end
        chk(irqn[1] == 2, "R7 pulse per burst", irqn[1], 2);
        wreg(1, 3, 32'd0);
        clear_log();
        wreg(1, 2, 32'd1);
        wreg(1, 3, cw(1, 2'd1, 0, 0, 1, 2'd0, 2'd0));
        pulse_blank(1);
        quiet();
        pulse_blank(1);
        quiet();
        chk(nw == 1, "R7 no repeat clears enable", nw, 1);
    endtask

    task automatic t_count_zero();
        clear_log();
        setup(3, 32'h0300_0000, 32'h0280_0000, 0);
        wreg(3, 3, cw(1, 2'd0, 0, 0, 1, 2'd0, 2'd0));
        quiet();
        chk(nw == (1 << CW) - 1, "R4 count zero gives all-ones", nw, (1 << CW) - 1);
        chk(wa[(1 << CW) - 2] == 32'h0280_0000 + 4 * ((1 << CW) - 2), "R4 last address",
            wa[(1 << CW) - 2], 32'h0280_0000 + 4 * ((1 << CW) - 2));
    endtask

    task automatic t_audio();
        clear_log();
        setup(2, 32'h0130_0000, 32'h0400_00A4, 9);
        wreg(2, 3, cw(1, 2'd3, 0, 1, 0, 2'd0, 2'd0));
        quiet();
        chk(nw == 0, "R3 audio mode waits after enable", nw, 0);
        pulse_snd(1);
        repeat (3) @(negedge clk);
        pulse_snd(1);
        quiet();
        chk(nw == 4, "R10 request while busy ignored", nw, 4);
        pulse_snd(1);
        quiet();
        chk(nw == 8, "R9 repeat forced, second burst", nw, 8);
        for (int i = 0; i < 8; i++) begin
            chk(wa[i] == 32'h0400_00A4 && ww[i], "R9 fixed 32-bit destination", wa[i], 32'h0400_00A4);
            chk(ra[i] == 32'h0130_0000 + 4 * i, "R9 source steps by 4", ra[i], 32'h0130_0000 + 4 * i);
        end
        chk(irqn[2] == 2, "R9 pulse per burst", irqn[2], 2);
        clear_log();
        setup(1, 32'h0130_0000, 32'h0400_00A0, 1);
        wreg(1, 3, cw(1, 2'd1, 0, 0, 1, 2'd0, 2'd0));
        pulse_snd(0);
        quiet();
        chk(nw == 0, "R10 request ignored outside audio mode", nw, 0);
        wreg(1, 3, 32'd0);
    endtask

    task automatic t_mask();
        clear_log();
        setup(0, 32'hFFFF_FFF0, 32'hFFFF_FF00, 1);
        wreg(0, 3, cw(1, 2'd0, 0, 0, 1, 2'd0, 2'd0));
        quiet();
        setup(3, 32'hFFFF_FFF0, 32'hFFFF_FF00, 1);
        wreg(3, 3, cw(1, 2'd0, 0, 0, 1, 2'd0, 2'd0));
        quiet();
        chk(ra[0] == 32'h07FF_FFF0, "R5 channel 0 source 27 bits", ra[0], 32'h07FF_FFF0);
        chk(wa[0] == 32'h07FF_FF00, "R5 channel 0 destination 27 bits", wa[0], 32'h07FF_FF00);
        chk(ra[1] == 32'h0FFF_FFF0, "R5 channel 3 source 28 bits", ra[1], 32'h0FFF_FFF0);
        chk(wa[1] == 32'h0FFF_FF00, "R5 channel 3 destination 28 bits", wa[1], 32'h0FFF_FF00);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) irqn[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_half_dec();
        t_priority();
        t_blank();
        t_count_zero();
        t_audio();
        t_mask();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule